// File: doc/BRIEF.md
# Bus-Matching Width Adapter for a 36-bit FIFO Store

This block stands between narrow external buses and a FIFO store whose words are 36 bits wide. On the write side it collects 9-bit or 18-bit words from a valid/ready stream and hands the store one full 36-bit word. On the read side it takes one 36-bit word from the store and gives it out as a run of 18-bit or 9-bit words on a second valid/ready stream. Each side runs on its own clock. The store itself is outside the block: its RAM, pointers, flags and clock-domain crossing.

The width and the byte order come from configuration pins. These pins are taken in only while master reset is held. Only one side can be narrow at a time, so the allowed pairings are 36/36, 36/18, 36/9, 18/36 and 9/36. A partial reset discards any word that is half assembled or half delivered, and the configuration stays as it was.

Top module: `bus_width_adapter`

## Requirements
- R1: Encodings. With `cfg_match_en`=0 both sides are 36 bits wide. With `cfg_match_en`=1, `cfg_narrow_rd`=1 makes the read side narrow and 0 makes the write side narrow, and `cfg_narrow_x9`=1 selects 9 bits while 0 selects 18 bits. A narrow input word is taken from `in_data` bits [8:0] or [17:0], and the upper bits are ignored. A narrow output word appears on `out_data` bits [8:0] or [17:0], with every bit above it zero.
- R2: The configuration pins are captured on each clock edge of a side while `mrst_n` is low. Changes to them while `mrst_n` is high have no effect.
- R3: With `cfg_big_endian`=1 the first narrow word of a 36-bit word occupies its most significant slice. With 0 it occupies the least significant slice. The later words fill the following slices in order.
- R4: With a 9-bit input, four accepted words produce exactly one `store_we` pulse. With an 18-bit input, two accepted words produce one. `store_we` is raised in the cycle that accepts the last word and carries the complete word. With a 36-bit input, every accepted word is written.
- R5: `in_ready` equals the inverse of `store_full`. A word is accepted on each `wr_clk` edge where `in_valid` and `in_ready` are both high.
- R6: `store_re` is raised only while `store_empty` is low, and only when no word is held or the last slice of the held word is taken in that same cycle. `store_rdata` is captured on that edge.
- R7: A held word is delivered as four (9-bit) or two (18-bit) slices in the order given by R3, or as one 36-bit word. While `out_valid` is high and `out_ready` is low, `out_data` stays unchanged.
- R8: While `store_full` is high, input words are ignored. There is no `store_wdata` strobe, and the partial word and its slice position are kept.
- R9: `out_ready` pulses while `out_valid` is low have no effect. The next word held is still delivered from its first slice.
- R10: Either reset leaves `out_valid`, `store_we` and `store_re` low. `prst_n` low discards the partial write word and the held read word, and keeps the width and order settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, synchronous; captures configuration |
| prst_n | input | 1 | Partial reset, active low, synchronous; keeps configuration |
| cfg_match_en | input | 1 | Enables a narrow bus on one side |
| cfg_narrow_rd | input | 1 | 1: the narrow bus is on the read side, 0: on the write side |
| cfg_narrow_x9 | input | 1 | 1: the narrow width is 9 bits, 0: 18 bits |
| cfg_big_endian | input | 1 | 1: the first narrow word is in the most significant slice |
| in_data | input | 36 | Write-stream data |
| in_valid | input | 1 | Write-stream valid |
| in_ready | output | 1 | Write-stream ready |
| store_we | output | 1 | Store write strobe |
| store_wdata | output | 36 | Store write word |
| store_full | input | 1 | Store has no free word |
| store_empty | input | 1 | Store holds no word |
| store_re | output | 1 | Store read strobe (pops the head word) |
| store_rdata | input | 36 | Head word of the store, valid while not empty |
| out_valid | output | 1 | Read-stream valid |
| out_ready | input | 1 | Read-stream ready |
| out_data | output | 36 | Read-stream data |

## Verification
A slice index that is off by one shows up at once on the write side. In that case `store_wdata` carries a slice in the wrong position, or `store_we` fires after the wrong number of accepted words. Both are visible on the edge that completes a word. On the read side, a wrong slice index or a stale held-valid flag shows at the next handshake. The result is a slice out of order, a duplicated slice, or a word popped from the store before its predecessor was fully taken. An error in the configuration latch affects every word that follows, so it is caught within the first full word after reset.

// File: rtl/bwa_pkg.sv
// Shared constants and the per-side configuration type of the width adapter.
// Assumes the storage word is a whole number of narrowest lanes.
package bwa_pkg;
    localparam int LANE_W = 9;
    localparam int LANES  = 4;
    localparam int WORD_W = LANE_W * LANES;
    localparam int CNT_W  = $clog2(LANES);
    localparam int LG_W   = $clog2($clog2(LANES) + 1);

    // lg: log2 of lanes per external word on this side; big: slice order
    typedef struct packed {
        logic [LG_W-1:0] lg;
        logic            big;
    } side_cfg_t;
endpackage

// File: rtl/bwa_cfg_latch.sv
// Captures the width and byte order of one side while master reset is low.
// Assumes the configuration pins are stable around the reset edges.
module bwa_cfg_latch
    import bwa_pkg::*;
#(
    parameter bit READ_SIDE = 1'b0,
    parameter int NL        = LANES
) (
    input  logic      clk,
    input  logic      mrst_n,
    input  logic      match_en,
    input  logic      narrow_rd,
    input  logic      narrow_x9,
    input  logic      big_endian,
    output side_cfg_t cfg
);
    localparam logic [LG_W-1:0] LG_FULL = LG_W'($clog2(NL));

    logic narrow_here;
    assign narrow_here = match_en && (narrow_rd == READ_SIDE);

    // Sample the configuration only during master reset
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            cfg.lg  <= narrow_here ? (narrow_x9 ? LG_W'(0) : LG_W'(1)) : LG_FULL;
            cfg.big <= big_endian;
        end
    end
endmodule

// File: rtl/bwa_packer.sv
// Write side: merges narrow input words into one storage word and strobes
// the store when the last slice arrives. Assumes store_full is valid each cycle.
module bwa_packer
    import bwa_pkg::*;
#(
    parameter int LW = LANE_W,
    parameter int NL = LANES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  side_cfg_t       cfg,
    input  logic [NL*LW-1:0] in_data,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic            store_full,
    output logic            store_we,
    output logic [NL*LW-1:0] store_wdata
);
    localparam int WW = NL * LW;
    localparam int CW = $clog2(NL);

    logic [CW-1:0] idx, last_idx, pos, lane_mask;
    logic [WW-1:0] acc, merged;
    logic          accept, at_last;

    // Slice bookkeeping derived from the latched width and order
    always_comb begin
        last_idx  = CW'((NL >> cfg.lg) - 1);
        lane_mask = CW'((1 << cfg.lg) - 1);
        pos       = cfg.big ? (last_idx - idx) : idx;
        accept    = in_valid && !store_full;
        at_last   = (idx == last_idx);
    end

    // Place the incoming word's lanes into the slice selected by pos
    for (genvar k = 0; k < NL; k++) begin : g_lane
        logic          hit;
        logic [CW-1:0] src;
        assign hit = (CW'(k >> cfg.lg) == pos);
        assign src = CW'(k) & lane_mask;
        assign merged[k*LW +: LW] = hit ? in_data[src*LW +: LW] : acc[k*LW +: LW];
    end

    assign in_ready    = !store_full;
    assign store_we    = accept && at_last;
    assign store_wdata = merged;

    // Advance slice position and keep the partial word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
            acc <= '0;
        end else if (accept) begin
            if (at_last) begin
                idx <= '0;
                acc <= '0;
            end else begin
                idx <= idx + 1'b1;
                acc <= merged;
            end
        end
    end
endmodule

// File: rtl/bwa_unpacker.sv
// Read side: holds one storage word and hands it out slice by slice,
// fetching the next word as the last slice goes. Assumes store_rdata shows
// the head word whenever store_empty is low.
module bwa_unpacker
    import bwa_pkg::*;
#(
    parameter int LW = LANE_W,
    parameter int NL = LANES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  side_cfg_t       cfg,
    input  logic [NL*LW-1:0] store_rdata,
    input  logic            store_empty,
    output logic            store_re,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [NL*LW-1:0] out_data
);
    localparam int WW = NL * LW;
    localparam int CW = $clog2(NL);

    logic [WW-1:0] held;
    logic          held_v;
    logic [CW-1:0] idx, last_idx, pos;
    logic          take, at_last;

    // Handshake and slice position
    always_comb begin
        last_idx = CW'((NL >> cfg.lg) - 1);
        pos      = cfg.big ? (last_idx - idx) : idx;
        take     = held_v && out_ready;
        at_last  = (idx == last_idx);
        store_re = !store_empty && (!held_v || (take && at_last));
    end

    // Route the selected slice to the low lanes, zero above
    for (genvar j = 0; j < NL; j++) begin : g_out
        logic [CW-1:0] lane;
        logic          active;
        assign lane   = CW'((int'(pos) << cfg.lg) | j);
        assign active = ((j >> cfg.lg) == 0);
        assign out_data[j*LW +: LW] = (held_v && active) ? held[lane*LW +: LW] : '0;
    end

    assign out_valid = held_v;

    // Load a new word or step through the held one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held   <= '0;
            held_v <= 1'b0;
            idx    <= '0;
        end else if (store_re) begin
            held   <= store_rdata;
            held_v <= 1'b1;
            idx    <= '0;
        end else if (take) begin
            if (at_last) begin
                held_v <= 1'b0;
                idx    <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bus_width_adapter.sv
// Top: write-side packer and read-side unpacker around a 36-bit store, each
// with its own configuration latch and clock. Resets are synchronous per side.
module bus_width_adapter
    import bwa_pkg::*;
#(
    parameter int LW = LANE_W,
    parameter int NL = LANES
) (
    input  logic            wr_clk,
    input  logic            rd_clk,
    input  logic            mrst_n,
    input  logic            prst_n,
    input  logic            cfg_match_en,
    input  logic            cfg_narrow_rd,
    input  logic            cfg_narrow_x9,
    input  logic            cfg_big_endian,
    input  logic [NL*LW-1:0] in_data,
    input  logic            in_valid,
    output logic            in_ready,
    output logic            store_we,
    output logic [NL*LW-1:0] store_wdata,
    input  logic            store_full,
    input  logic            store_empty,
    output logic            store_re,
    input  logic [NL*LW-1:0] store_rdata,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [NL*LW-1:0] out_data
);
    side_cfg_t wr_cfg, rd_cfg;
    logic      side_rst_n;

    assign side_rst_n = mrst_n && prst_n;

    bwa_cfg_latch #(.READ_SIDE(1'b0), .NL(NL)) u_wr_cfg (
        .clk(wr_clk), .mrst_n(mrst_n), .match_en(cfg_match_en),
        .narrow_rd(cfg_narrow_rd), .narrow_x9(cfg_narrow_x9),
        .big_endian(cfg_big_endian), .cfg(wr_cfg)
    );

    bwa_cfg_latch #(.READ_SIDE(1'b1), .NL(NL)) u_rd_cfg (
        .clk(rd_clk), .mrst_n(mrst_n), .match_en(cfg_match_en),
        .narrow_rd(cfg_narrow_rd), .narrow_x9(cfg_narrow_x9),
        .big_endian(cfg_big_endian), .cfg(rd_cfg)
    );

    bwa_packer #(.LW(LW), .NL(NL)) u_pack (
        .clk(wr_clk), .rst_n(side_rst_n), .cfg(wr_cfg),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .store_full(store_full), .store_we(store_we), .store_wdata(store_wdata)
    );

    bwa_unpacker #(.LW(LW), .NL(NL)) u_unpack (
        .clk(rd_clk), .rst_n(side_rst_n), .cfg(rd_cfg),
        .store_rdata(store_rdata), .store_empty(store_empty), .store_re(store_re),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );
endmodule

// File: rtl/bwa_checker.sv
// Protocol checks for bus_width_adapter, attached by bind. Counts handshakes
// per word to relate strobes to the latched widths.
module bwa_checker
    import bwa_pkg::*;
#(
    parameter int LW = LANE_W,
    parameter int NL = LANES
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             mrst_n,
    input logic             prst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             store_we,
    input logic             store_full,
    input logic             store_re,
    input logic             store_empty,
    input logic             out_valid,
    input logic             out_ready,
    input logic [NL*LW-1:0] out_data,
    input logic [LG_W-1:0]  wr_lg,
    input logic [LG_W-1:0]  rd_lg
);
    logic [CNT_W:0] wr_seen, rd_seen;

    // Words accepted since the last store write
    always_ff @(posedge wr_clk) begin
        if (!(mrst_n && prst_n))        wr_seen <= '0;
        else if (in_valid && in_ready)  wr_seen <= store_we ? '0 : wr_seen + 1'b1;
    end

    // Slices taken since the last store read
    always_ff @(posedge rd_clk) begin
        if (!(mrst_n && prst_n))          rd_seen <= '0;
        else if (store_re)                rd_seen <= '0;
        else if (out_valid && out_ready)  rd_seen <= rd_seen + 1'b1;
    end

    a_r2_wr_cfg_hold: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        mrst_n |=> $stable(wr_lg));
    a_r2_rd_cfg_hold: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        mrst_n |=> $stable(rd_lg));
    a_r4_pack_count: assert property (@(posedge wr_clk) disable iff (!(mrst_n && prst_n))
        store_we |-> (32'(wr_seen) + 1 == (NL >> wr_lg)));
    a_r8_no_write_full: assert property (@(posedge wr_clk) disable iff (!(mrst_n && prst_n))
        store_full |-> (!store_we && !in_ready));
    a_r6_no_read_empty: assert property (@(posedge rd_clk) disable iff (!(mrst_n && prst_n))
        store_re |-> !store_empty);
    a_r6_refill_after_last: assert property (@(posedge rd_clk) disable iff (!(mrst_n && prst_n))
        (store_re && out_valid) |-> (32'(rd_seen) + 1 == (NL >> rd_lg)));
    a_r7_hold_on_stall: assert property (@(posedge rd_clk) disable iff (!(mrst_n && prst_n))
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind bus_width_adapter bwa_checker #(.LW(LW), .NL(NL)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .in_valid(in_valid), .in_ready(in_ready), .store_we(store_we),
    .store_full(store_full), .store_re(store_re), .store_empty(store_empty),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .wr_lg(wr_cfg.lg), .rd_lg(rd_cfg.lg)
);

// File: tb/sim_bus_width_adapter.sv
// Bench: models a small store queue, drives random traffic per mode and
// compares store writes and output slices against a packing model.
module sim_bus_width_adapter;
    localparam int PERIOD = 10;
    localparam int CAP    = 3;

    logic        clk = 1'b0;
    logic        mrst_n = 1'b0, prst_n = 1'b1;
    logic        cfg_match_en = 0, cfg_narrow_rd = 0, cfg_narrow_x9 = 0, cfg_big_endian = 0;
    logic [35:0] in_data = '0;
    logic        in_valid = 0, out_ready = 0;
    logic        store_full = 0, store_empty = 1;
    logic [35:0] store_rdata = '0;
    logic        in_ready, store_we, store_re, out_valid;
    logic [35:0] store_wdata, out_data;

    int n_vec = 0, n_bad = 0;
    logic [35:0] sq[$];
    logic [35:0] exp_store[$];
    logic [35:0] exp_out[$];
    int          m_wr_lanes = 4, m_rd_lanes = 4, wr_idx = 0, outs_seen = 0;
    bit          m_big = 0;
    logic [35:0] wr_acc = '0;

    always #(PERIOD/2) clk = ~clk;

    bus_width_adapter u0 (
        .wr_clk(clk), .rd_clk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .cfg_match_en(cfg_match_en), .cfg_narrow_rd(cfg_narrow_rd),
        .cfg_narrow_x9(cfg_narrow_x9), .cfg_big_endian(cfg_big_endian),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .store_we(store_we), .store_wdata(store_wdata), .store_full(store_full),
        .store_empty(store_empty), .store_re(store_re), .store_rdata(store_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] lane_mask(input int lanes);
        return (36'd1 << (lanes * 9)) - 36'd1;
    endfunction

    task automatic drive_store();
        store_empty = (sq.size() == 0);
        store_full  = (sq.size() >= CAP);
        store_rdata = (sq.size() != 0) ? sq[0] : '0;
    endtask

    // Expected output slices of one storage word (R3, R7)
    task automatic push_out(input logic [35:0] w);
        if (m_rd_lanes == 4) exp_out.push_back(w);
        else begin
            int n = 4 / m_rd_lanes;
            for (int i = 0; i < n; i++) begin
                int p = m_big ? (n - 1 - i) : i;
                exp_out.push_back((w >> (p * m_rd_lanes * 9)) & lane_mask(m_rd_lanes));
            end
        end
    endtask

    // Expected packing of one accepted input word (R1, R3, R4)
    task automatic model_write(input logic [35:0] d);
        if (m_wr_lanes == 4) begin
            exp_store.push_back(d);
            push_out(d);
        end else begin
            int n  = 4 / m_wr_lanes;
            int p  = m_big ? (n - 1 - wr_idx) : wr_idx;
            int sh = p * m_wr_lanes * 9;
            logic [35:0] mk = lane_mask(m_wr_lanes);
            wr_acc = (wr_acc & ~(mk << sh)) | ((d & mk) << sh);
            if (wr_idx == n - 1) begin
                exp_store.push_back(wr_acc);
                push_out(wr_acc);
                wr_acc = '0;
                wr_idx = 0;
            end else wr_idx++;
        end
    endtask

    task automatic clear_model();
        sq.delete(); exp_store.delete(); exp_out.delete();
        wr_idx = 0; wr_acc = '0;
    endtask

    // One clock: called at a negedge after inputs are driven
    task automatic cycle();
        bit we, re;
        logic [35:0] wd, e;
        #(PERIOD/2 - 1);
        if (mrst_n && prst_n) begin
            check(in_ready == !store_full, "R5", 36'(in_ready), 36'(!store_full));
            if (store_full)  check(!store_we, "R8", 36'(store_we), 36'd0);
            if (store_empty) check(!store_re, "R6", 36'(store_re), 36'd0);
            if (in_valid && in_ready) model_write(in_data);
            if (store_we) begin
                e = (exp_store.size() != 0) ? exp_store.pop_front() : 36'hx;
                check(store_wdata === e, "R4", store_wdata, e);
            end
            if (out_valid && out_ready) begin
                e = (exp_out.size() != 0) ? exp_out.pop_front() : 36'hx;
                check(out_data === e, "R7", out_data, e);
                outs_seen++;
            end
        end
        we = store_we; re = store_re; wd = store_wdata;
        @(posedge clk);
        #1;
        if (!mrst_n || !prst_n) clear_model();
        else begin
            if (re && sq.size() != 0) void'(sq.pop_front());
            if (we) sq.push_back(wd);
        end
        drive_store();
        @(negedge clk);
    endtask

    task automatic run_mode(input bit en, input bit rd, input bit x9, input bit big,
                            input int ncyc, input bit do_prst);
        cfg_match_en = en; cfg_narrow_rd = rd; cfg_narrow_x9 = x9; cfg_big_endian = big;
        in_valid = 0; out_ready = 0; mrst_n = 0;
        cycle(); cycle();
        m_wr_lanes = (en && !rd) ? (x9 ? 1 : 2) : 4;
        m_rd_lanes = (en &&  rd) ? (x9 ? 1 : 2) : 4;
        m_big = big; outs_seen = 0;
        mrst_n = 1;
        // R2: scramble the configuration pins after reset
        {cfg_match_en, cfg_narrow_rd, cfg_narrow_x9, cfg_big_endian} = 4'($urandom());
        #1;
        check(!out_valid && !store_we && !store_re, "R10",
              36'({out_valid, store_we, store_re}), 36'd0);
        // R9: reads with nothing held are ignored
        for (int i = 0; i < 3; i++) begin
            out_ready = 1;
            #1;
            check(!out_valid, "R9", 36'(out_valid), 36'd0);
            cycle();
        end
        for (int i = 0; i < ncyc; i++) begin
            if (do_prst && i == ncyc / 2) begin
                // R10: partial reset after two narrow words
                in_valid = 1; out_ready = 0; in_data = 36'h0_0000_01AB; cycle();
                in_valid = 1; in_data = 36'h0_0000_00CD; cycle();
                in_valid = 0; prst_n = 0; cycle();
                prst_n = 1;
            end
            in_valid  = ($urandom() % 10) < 7;
            in_data   = {4'($urandom()), $urandom()};
            out_ready = ($urandom() % 10) < 6;
            if (($urandom() % 16) == 0)
                {cfg_match_en, cfg_narrow_rd, cfg_narrow_x9, cfg_big_endian} = 4'($urandom());
            cycle();
        end
        check(outs_seen > 0, "R1", 36'(outs_seen), 36'd1);
    endtask

    initial begin
        void'($urandom(32'd715));
        drive_store();
        @(negedge clk);
        run_mode(0, 0, 0, 0, 300, 0);
        run_mode(1, 0, 1, 1, 400, 1);
        run_mode(1, 0, 1, 0, 400, 0);
        run_mode(1, 0, 0, 1, 300, 0);
        run_mode(1, 0, 0, 0, 300, 1);
        run_mode(1, 1, 0, 0, 300, 0);
        run_mode(1, 1, 1, 1, 400, 1);
        run_mode(1, 1, 1, 0, 400, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 36'd0, 36'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule